// File: doc/BRIEF.md
# Configurable SPI Master Shift Engine

This block is the serial core of an SPI master. It takes words from a transmit stream, shifts each one out on MOSI most significant bit first, and assembles the bits sampled at the same time into a received word. That received word is offered on a receive stream. A static control word sets the frame size, clock polarity and phase, loopback, frame format and transfer mode. Three further inputs are held steady while the engine runs: a baud divider, a slave-enable mask and a receive sample delay. A global enable starts the engine, and clearing it returns the engine to rest.

A build parameter selects one of two bit layouts for the control word, so the same engine can serve either register map. Frames are started only when the engine is enabled, at least one slave line is enabled, the divider is usable and a received word would have somewhere to go. Back-pressure rules on the streams: a transmit word is taken only on a cycle where `tx_valid` and `tx_ready` are both high. `tx_ready` is never raised while a received word is still waiting on `rx_valid`. A received word stays on `rx_data` with `rx_valid` high until `rx_ready` accepts it. The slave-select lines stay asserted from one frame to the next while words keep arriving.

Top module: `spi_frame_engine`

## Requirements
- R1: Control word bits 3:0 hold the frame size minus one; sizes 4 to 16 bits are supported, and field values 0 to 2 are treated as a 4-bit frame.
- R2: With the default layout, format sits at bits 5:4, phase at bit 6, polarity at bit 7, transfer mode at bits 9:8 and loopback at bit 11.
- R3: With the alternate layout, format sits at bits 7:6, phase at bit 8, polarity at bit 9, transfer mode at bits 11:10 and loopback at bit 13.
- R4: SCLK rests at the polarity bit. With phase 0, MOSI launches on trailing edges and the receive bit is sampled on leading edges. With phase 1, MOSI launches on leading edges and the receive bit is sampled on trailing edges. Bits go out MSB first.
- R5: The SCLK period is the divider value with its bit 0 cleared, counted in system clocks; a divider of 0 or 1 starts no frame.
- R6: No frame starts while every slave-enable bit is 0; during a frame, `ss_n[i]` is low exactly for the enabled bits `i`.
- R7: One cycle after the global enable goes low, the engine is at rest: all `ss_n` are high and `rx_valid` is low, and no received word for the aborted frame appears afterwards.
- R8: With loopback set, the received word equals the transmitted word, MISO is ignored and the sample delay has no effect.
- R9: Each frame shifted produces exactly one received word, right-aligned and zero-extended, held stable until accepted.
- R10: With loopback clear, MISO is captured `rx_delay` system clocks after each sampling edge.
- R11: No transmit word is taken while `rx_valid` is high; while waiting for that, and between back-to-back frames, the slave selects stay asserted.
- R12: A frame starts only when the format field and the transfer mode field are both 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| engine_en | input | 1 | Global enable; low aborts and idles the engine |
| ctrl_word | input | CW | Control word (frame size, format, phase, polarity, mode, loopback) |
| baud_div | input | DIVW | SCLK divider; bit 0 ignored |
| slave_en | input | NSS | Slave-enable mask |
| rx_delay | input | DLYW | MISO capture delay in system clocks |
| tx_valid | input | 1 | Transmit word available |
| tx_ready | output | 1 | Transmit word taken this cycle |
| tx_data | input | 16 | Transmit word, right-aligned |
| rx_valid | output | 1 | Received word available |
| rx_ready | input | 1 | Consumer accepts received word |
| rx_data | output | 16 | Received word, right-aligned |
| miso | input | 1 | Serial data from slave |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to slave |
| ss_n | output | NSS | Active-low slave selects |

## Verification
The hardest situation to reach is a slave whose MISO arrives late enough that sampling on the clock edge takes the previous bit. The bench runs a slave model with a programmable lag in system clocks. At that lag, a zero capture delay must corrupt the word, and a small nonzero delay must recover it. A second hard case is the engine parked between frames with the selects still low, because the receive word is not being accepted. The bench holds `rx_ready` low with several words queued, checks that only one word has been taken, and then releases it.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;
  localparam int unsigned WMAX = 16;
  localparam int unsigned NBW  = $clog2(WMAX + 1);
  localparam int unsigned EIW  = NBW + 1;

  typedef struct packed {
    logic [NBW-1:0] nbits;
    logic           cpol;
    logic           cpha;
    logic           loopb;
    logic [1:0]     fmt;
    logic [1:0]     tmode;
  } spi_cfg_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_DRAIN = 2'd2,
    ST_GAP   = 2'd3
  } eng_state_t;
endpackage

// File: rtl/spi_cfg_decode.sv
module spi_cfg_decode
  import spi_eng_pkg::*;
#(
  parameter bit ALT_LAYOUT = 1'b0,
  parameter int CW         = 16
) (
  input  logic [CW-1:0] ctrl,
  output spi_cfg_t      cfg
);
  localparam int MIN_CW = 14;
  logic [3:0] size_m1;

  initial begin
    if (CW < MIN_CW) $error("control word too narrow");
  end

  assign size_m1   = ctrl[3:0];
  assign cfg.nbits = (size_m1 < 4'd3) ? NBW'(4) : (NBW'(size_m1) + NBW'(1));

  generate
    if (ALT_LAYOUT) begin : g_alt
      assign cfg.fmt   = ctrl[7:6];
      assign cfg.cpha  = ctrl[8];
      assign cfg.cpol  = ctrl[9];
      assign cfg.tmode = ctrl[11:10];
      assign cfg.loopb = ctrl[13];
    end else begin : g_std
      assign cfg.fmt   = ctrl[5:4];
      assign cfg.cpha  = ctrl[6];
      assign cfg.cpol  = ctrl[7];
      assign cfg.tmode = ctrl[9:8];
      assign cfg.loopb = ctrl[11];
    end
  endgenerate
endmodule

// File: rtl/spi_sclk_timer.sv
module spi_sclk_timer #(
  parameter int DIVW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic [DIVW-1:0] div_raw,
  output logic            edge_ev,
  output logic            div_ok
);
  localparam int HW = DIVW - 1;
  logic [HW-1:0] half;
  logic [HW-1:0] hc_q;

  assign half    = div_raw[DIVW-1:1];
  assign div_ok  = (half != '0);
  assign edge_ev = run && (hc_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              hc_q <= '0;
    else if (!run || hc_q == '0) hc_q <= half - HW'(1);
    else                     hc_q <= hc_q - HW'(1);
  end

  AST_HALF_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (hc_q < half)); // R5
endmodule

// File: rtl/spi_rx_capture.sv
module spi_rx_capture #(
  parameter int W    = 16,
  parameter int DLYW = 3,
  parameter int CNTW = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clear,
  input  logic            strobe,
  input  logic            bypass,
  input  logic [DLYW-1:0] dly,
  input  logic            din_ext,
  input  logic            din_loop,
  output logic [W-1:0]    word,
  output logic [CNTW-1:0] count
);
  localparam int DEPTH = (1 << DLYW) - 1;
  logic [DEPTH:1] chain_q;
  logic [DEPTH:0] taps;
  logic           fire;
  logic           bit_in;

  assign taps   = {chain_q, strobe};
  assign fire   = bypass ? strobe : taps[dly];
  assign bit_in = bypass ? din_loop : din_ext;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      word    <= '0;
      count   <= '0;
    end else if (clear) begin
      chain_q <= '0;
      word    <= '0;
      count   <= '0;
    end else begin
      chain_q <= taps[DEPTH-1:0];
      if (fire) begin
        word  <= {word[W-2:0], bit_in};
        count <= count + CNTW'(1);
      end
    end
  end

  AST_COUNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNTW'(W)); // R9
endmodule

// File: rtl/spi_frame_engine.sv
module spi_frame_engine
  import spi_eng_pkg::*;
#(
  parameter bit ALT_LAYOUT = 1'b0,
  parameter int CW         = 16,
  parameter int DIVW       = 16,
  parameter int NSS        = 4,
  parameter int DLYW       = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               engine_en,
  input  logic [CW-1:0]      ctrl_word,
  input  logic [DIVW-1:0]    baud_div,
  input  logic [NSS-1:0]     slave_en,
  input  logic [DLYW-1:0]    rx_delay,
  input  logic               tx_valid,
  output logic               tx_ready,
  input  logic [WMAX-1:0]    tx_data,
  output logic               rx_valid,
  input  logic               rx_ready,
  output logic [WMAX-1:0]    rx_data,
  input  logic               miso,
  output logic               sclk,
  output logic               mosi,
  output logic [NSS-1:0]     ss_n
);
  localparam int IDXW = $clog2(WMAX);

  spi_cfg_t       cfg;
  eng_state_t     state;
  logic [WMAX-1:0] txsr;
  logic [EIW-1:0] eidx;
  logic [EIW-1:0] last_e;
  logic [IDXW-1:0] msb_idx;
  logic           edge_ev, div_ok, cfg_ok, go, active;
  logic           leading, samp_ev, launch, tx_bit;
  logic [WMAX-1:0] cap_word;
  logic [NBW-1:0] cap_cnt;

  spi_cfg_decode #(.ALT_LAYOUT(ALT_LAYOUT), .CW(CW)) u_dec (
    .ctrl(ctrl_word), .cfg(cfg)
  );

  spi_sclk_timer #(.DIVW(DIVW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .run(state == ST_SHIFT),
    .div_raw(baud_div), .edge_ev(edge_ev), .div_ok(div_ok)
  );

  spi_rx_capture #(.W(WMAX), .DLYW(DLYW), .CNTW(NBW)) u_cap (
    .clk(clk), .rst_n(rst_n), .clear(tx_ready), .strobe(samp_ev),
    .bypass(cfg.loopb), .dly(rx_delay), .din_ext(miso), .din_loop(tx_bit),
    .word(cap_word), .count(cap_cnt)
  );

  always_comb begin
    active   = (state != ST_IDLE);
    cfg_ok   = (cfg.fmt == 2'b00) && (cfg.tmode == 2'b00);
    go       = engine_en && (|slave_en) && div_ok && cfg_ok && tx_valid && !rx_valid;
    tx_ready = ((state == ST_IDLE) || (state == ST_GAP)) && go;
    last_e   = EIW'({cfg.nbits, 1'b0}) - EIW'(1);
    msb_idx  = IDXW'(cfg.nbits - NBW'(1));
    tx_bit   = txsr[msb_idx];
    leading  = ~eidx[0];
    samp_ev  = edge_ev && (leading ^ cfg.cpha);
    launch   = edge_ev && (cfg.cpha ? (leading && (eidx != '0))
                                    : (!leading && (eidx != last_e)));
    mosi     = active ? tx_bit : 1'b0;
    ss_n     = ~(slave_en & {NSS{active}});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      sclk     <= 1'b0;
      txsr     <= '0;
      eidx     <= '0;
      rx_valid <= 1'b0;
      rx_data  <= '0;
    end else if (!engine_en) begin
      state    <= ST_IDLE;
      sclk     <= cfg.cpol;
      eidx     <= '0;
      rx_valid <= 1'b0;
    end else begin
      if (rx_valid && rx_ready) rx_valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          sclk <= cfg.cpol;
          if (go) begin
            state <= ST_SHIFT;
            txsr  <= tx_data;
            eidx  <= '0;
          end
        end
        ST_SHIFT: begin
          if (edge_ev) begin
            sclk <= ~sclk;
            eidx <= eidx + EIW'(1);
            if (launch) txsr <= txsr << 1;
            if (eidx == last_e) state <= ST_DRAIN;
          end
        end
        ST_DRAIN: begin
          if (cap_cnt == cfg.nbits) begin
            rx_valid <= 1'b1;
            rx_data  <= cap_word;
            state    <= ST_GAP;
          end
        end
        default: begin
          if (go) begin
            state <= ST_SHIFT;
            txsr  <= tx_data;
            eidx  <= '0;
          end else if (!tx_valid || !(|slave_en) || !div_ok || !cfg_ok) begin
            state <= ST_IDLE;
          end
        end
      endcase
    end
  end

  AST_NO_POP_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SHIFT) |-> !rx_valid); // R11
  AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !engine_en |=> (state == ST_IDLE && !rx_valid)); // R7
  AST_SCLK_REST_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_GAP) |-> (sclk == cfg.cpol)); // R4
  AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready && engine_en) |=> (rx_valid && $stable(rx_data))); // R9
  AST_DRAIN_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DRAIN) |-> (cap_cnt <= cfg.nbits)); // R9
endmodule

// File: tb/spi_frame_engine_bench.sv
module spi_frame_engine_bench;
  localparam int NSS = 2;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  int total = 0, bad = 0, cyc = 0;
  always @(posedge clk) cyc++;

  // stimulus state
  bit t_alt = 0, t_pol = 0, t_pha = 0, t_lb = 0, slave_on = 1;
  int t_n = 8, t_lag = 0;
  logic [1:0] t_fmt = 0, t_tm = 0;
  logic en = 0;
  logic [15:0] ctrl = 0, div = 16'd4;
  logic [NSS-1:0] se = 2'b01;
  logic [2:0] dly = 0;
  logic tx_valid = 0, rx_ready = 1, miso = 1;
  logic [15:0] tx_data = 0;

  logic tr0, tr1, rv0, rv1, sc0, sc1, mo0, mo1;
  logic [15:0] rd0, rd1;
  logic [NSS-1:0] sn0, sn1;
  logic tx_ready, rx_valid, sclk, mosi;
  logic [15:0] rx_data;
  logic [NSS-1:0] ss_n;

  spi_frame_engine #(.ALT_LAYOUT(1'b0), .NSS(NSS)) u_spi_frame_engine (
    .clk(clk), .rst_n(rst_n), .engine_en(en && !t_alt), .ctrl_word(ctrl),
    .baud_div(div), .slave_en(se), .rx_delay(dly), .tx_valid(tx_valid),
    .tx_ready(tr0), .tx_data(tx_data), .rx_valid(rv0), .rx_ready(rx_ready),
    .rx_data(rd0), .miso(miso), .sclk(sc0), .mosi(mo0), .ss_n(sn0));

  spi_frame_engine #(.ALT_LAYOUT(1'b1), .NSS(NSS)) u_spi_frame_engine_alt (
    .clk(clk), .rst_n(rst_n), .engine_en(en && t_alt), .ctrl_word(ctrl),
    .baud_div(div), .slave_en(se), .rx_delay(dly), .tx_valid(tx_valid),
    .tx_ready(tr1), .tx_data(tx_data), .rx_valid(rv1), .rx_ready(rx_ready),
    .rx_data(rd1), .miso(miso), .sclk(sc1), .mosi(mo1), .ss_n(sn1));

  assign tx_ready = t_alt ? tr1 : tr0;
  assign rx_valid = t_alt ? rv1 : rv0;
  assign rx_data  = t_alt ? rd1 : rd0;
  assign sclk     = t_alt ? sc1 : sc0;
  assign mosi     = t_alt ? mo1 : mo0;
  assign ss_n     = t_alt ? sn1 : sn0;

  function automatic logic [15:0] mask(int n);
    return 16'((32'd1 << n) - 1);
  endfunction
  function automatic logic [15:0] sword(int f);
    return (16'hC35A ^ 16'(f * 11079)) & mask(t_n);
  endfunction
  function automatic logic [15:0] tword(int f);
    return (16'(16'h5E21 + f * 7919) ^ 16'(t_n * 3)) & mask(t_n);
  endfunction
  function automatic logic [15:0] mk_ctrl(bit alt, int n, bit pol, bit pha, bit lb,
                                          logic [1:0] fmt, logic [1:0] tm);
    logic [15:0] c;
    c = 16'(n - 1) & 16'h000F;
    if (alt) begin
      c[7:6] = fmt; c[8] = pha; c[9] = pol; c[11:10] = tm; c[13] = lb;
    end else begin
      c[5:4] = fmt; c[6] = pha; c[7] = pol; c[9:8] = tm; c[11] = lb;
    end
    return c;
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // slave model: launches its words and records MOSI at its sampling edges
  logic [15:0] smosi [0:7];
  logic [15:0] rxw [0:7];
  int rxcnt = 0, pops = 0, falls = 0, per_bad = 0, leads = 0, last_lead = 0;
  int sl_k = 0, sm_k = 0, pend_cnt = 0;
  bit pend_act = 0, pend_val = 0, prev_act = 0, prev_sclk = 0;
  logic [NSS-1:0] last_ss = '1;

  task automatic launch_bit();
    int f, b;
    bit v;
    f = sl_k / t_n;
    b = t_n - 1 - (sl_k % t_n);
    v = (f < 8) ? sword(f)[b] : 1'b0;
    sl_k++;
    if (!slave_on) return;
    if (t_lag == 0) miso = v;
    else begin pend_act = 1; pend_val = v; pend_cnt = t_lag - 1; end
  endtask

  always @(negedge clk) begin
    bit act, lead;
    act = ~&ss_n;
    if (pend_act) begin
      if (pend_cnt == 0) begin miso = pend_val; pend_act = 0; end
      else pend_cnt--;
    end
    if (!slave_on) miso = 1'b1;
    if (act && !prev_act) begin
      sl_k = 0; sm_k = 0; leads = 0; falls++;
      if (!t_pha) launch_bit();
    end
    if (act) last_ss = ss_n;
    if (act && sclk != prev_sclk) begin
      lead = (sclk != t_pol);
      if (lead) begin
        if ((leads % t_n) != 0 && (cyc - last_lead) != int'(div & 16'hFFFE)) per_bad++;
        last_lead = cyc;
        leads++;
      end
      if (lead == !t_pha) begin
        if (sm_k / t_n < 8) smosi[sm_k / t_n][t_n - 1 - (sm_k % t_n)] = mosi;
        sm_k++;
      end else launch_bit();
    end
    prev_sclk = sclk;
    prev_act = act;
  end

  task automatic setup(bit alt, int n, bit pol, bit pha, bit lb, logic [1:0] fmt,
                       logic [1:0] tm, logic [15:0] d, logic [2:0] dl,
                       logic [NSS-1:0] s, bit son, int lag);
    @(negedge clk);
    en = 0;
    @(negedge clk);
    t_alt = alt; t_n = n; t_pol = pol; t_pha = pha; t_lb = lb; t_fmt = fmt; t_tm = tm;
    ctrl = mk_ctrl(alt, n, pol, pha, lb, fmt, tm);
    div = d; dly = dl; se = s; slave_on = son; t_lag = lag;
    pend_act = 0; miso = 1;
    @(negedge clk);
    en = 1;
    falls = 0; per_bad = 0;
    for (int i = 0; i < 8; i++) smosi[i] = 16'h0;
    @(negedge clk);
  endtask

  task automatic run_xfer(int nfr, int maxcyc);
    rxcnt = 0; pops = 0;
    fork
      begin
        int idx = 0, t = 0;
        while (idx < nfr && t < maxcyc) begin
          @(negedge clk);
          tx_valid = 1; tx_data = tword(idx);
          #1;
          if (tx_ready) begin idx++; pops++; end
          t++;
        end
        @(negedge clk);
        tx_valid = 0;
      end
      begin
        int t = 0;
        while (rxcnt < nfr && t < maxcyc) begin
          @(negedge clk);
          #1;
          if (rx_valid && rx_ready) begin rxw[rxcnt] = rx_data; rxcnt++; end
          t++;
        end
      end
    join
    repeat (3) @(negedge clk);
  endtask

  task automatic idle_window(int cycles, output int np, output bit selected);
    np = 0; selected = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      tx_valid = 1; tx_data = 16'h00A5;
      #1;
      if (tx_ready) np++;
      if (~&ss_n) selected = 1;
    end
    @(negedge clk);
    tx_valid = 0;
  endtask

  task automatic check_frames(int nfr, string req);
    chk(rxcnt == nfr, req, "rx word count (R9)", rxcnt, nfr);
    for (int f = 0; f < nfr && f < rxcnt; f++) begin
      logic [15:0] exp_rx;
      exp_rx = t_lb ? tword(f) : sword(f);
      chk(rxw[f] == exp_rx, req, "received word (R4/R9)", rxw[f], exp_rx);
      chk(smosi[f] == tword(f), req, "MOSI word seen by slave (R4)", smosi[f], tword(f));
    end
    chk(per_bad == 0, req, "SCLK period (R5)", per_bad, 0);
    chk(falls == 1, req, "select held across frames (R11)", falls, 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int np;
    bit selx;
    int sizes [5] = '{4, 5, 8, 11, 16};
    repeat (3) @(negedge clk);
    // reset state
    chk(ss_n == 2'b11, "R7", "reset ss_n", ss_n, 3);
    chk(rx_valid == 1'b0, "R9", "reset rx_valid", rx_valid, 0);
    chk(tx_ready == 1'b0, "R11", "reset tx_ready", tx_ready, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // sweep: both layouts, all modes, several sizes and dividers, external slave
    for (int a = 0; a < 2; a++)
      for (int m = 0; m < 4; m++)
        for (int s = 0; s < 5; s++)
          for (int dv = 0; dv < 2; dv++) begin
            setup(a[0], sizes[s], m[1], m[0], 0, 2'b00, 2'b00,
                  dv ? 16'd6 : 16'd2, 3'd0, 2'b01, 1, 0);
            @(negedge clk);
            chk(sclk == t_pol, a ? "R3" : "R2", "SCLK rest level (R4)", sclk, t_pol);
            run_xfer(2, 2000);
            check_frames(2, a ? "R3 R1" : "R2 R1");
          end

    // frame-size field below 3 acts as a 4-bit frame
    setup(0, 4, 0, 0, 0, 2'b00, 2'b00, 16'd2, 3'd0, 2'b01, 1, 0);
    en = 0; ctrl = mk_ctrl(0, 1, 0, 0, 0, 2'b00, 2'b00); @(negedge clk); en = 1;
    run_xfer(1, 1000);
    check_frames(1, "R1");

    // loopback: MISO forced high, delay set, word must come back unchanged
    for (int a = 0; a < 2; a++)
      for (int n = 4; n <= 16; n++) begin
        setup(a[0], n, n[0], n[1], 1, 2'b00, 2'b00, 16'd4, 3'd5, 2'b01, 0, 0);
        run_xfer(1, 1000);
        chk(rxcnt == 1 && rxw[0] == tword(0), "R8", "loopback word", rxw[0], tword(0));
      end

    // odd divider behaves like the even value below it
    setup(0, 8, 0, 1, 0, 2'b00, 2'b00, 16'd5, 3'd0, 2'b01, 1, 0);
    run_xfer(1, 1000);
    check_frames(1, "R5");
    for (int d = 0; d < 2; d++) begin
      setup(0, 8, 0, 0, 0, 2'b00, 2'b00, 16'(d), 3'd0, 2'b01, 1, 0);
      idle_window(200, np, selx);
      chk(np == 0 && !selx, "R5", "divider below 2 starts nothing", np, 0);
    end

    // slave enable
    setup(0, 8, 0, 0, 0, 2'b00, 2'b00, 16'd4, 3'd0, 2'b00, 1, 0);
    idle_window(200, np, selx);
    chk(np == 0 && !selx, "R6", "no slave enabled starts nothing", np, 0);
    setup(0, 8, 1, 0, 0, 2'b00, 2'b00, 16'd4, 3'd0, 2'b10, 1, 0);
    run_xfer(1, 1000);
    chk(last_ss == 2'b01, "R6", "select pattern follows mask", last_ss, 1);
    chk(rxcnt == 1 && rxw[0] == sword(0), "R6", "frame with upper select", rxw[0], sword(0));

    // format and mode fields must be zero
    for (int a = 0; a < 2; a++) begin
      setup(a[0], 8, 0, 0, 0, 2'b01, 2'b00, 16'd4, 3'd0, 2'b01, 1, 0);
      idle_window(150, np, selx);
      chk(np == 0, "R12", "nonzero format blocks frames", np, 0);
      setup(a[0], 8, 0, 0, 0, 2'b00, 2'b10, 16'd4, 3'd0, 2'b01, 1, 0);
      idle_window(150, np, selx);
      chk(np == 0, "R12", "nonzero transfer mode blocks frames", np, 0);
    end

    // late slave: zero delay corrupts, small delays recover
    setup(0, 8, 0, 0, 0, 2'b00, 2'b00, 16'd4, 3'd0, 2'b01, 1, 2);
    run_xfer(1, 1000);
    chk(rxcnt == 1 && rxw[0] != sword(0), "R10", "late MISO without delay differs", rxw[0], sword(0));
    for (int d = 1; d <= 3; d += 2) begin
      setup(0, 8, 0, 0, 0, 2'b00, 2'b00, 16'd4, 3'(d), 2'b01, 1, 2);
      run_xfer(2, 1000);
      check_frames(2, "R10");
    end

    // back-pressure on the receive side
    setup(0, 12, 1, 1, 0, 2'b00, 2'b00, 16'd4, 3'd0, 2'b01, 1, 0);
    rx_ready = 0;
    fork
      run_xfer(3, 4000);
      begin
        repeat (400) @(negedge clk);
        #1;
        chk(pops == 1, "R11", "only one word taken while rx held", pops, 1);
        chk(ss_n == 2'b10, "R11", "select held while waiting", ss_n, 2);
        chk(rx_valid == 1'b1, "R9", "received word held", rx_valid, 1);
        chk(rx_data == sword(0), "R9", "held word value", rx_data, sword(0));
        rx_ready = 1;
      end
    join
    check_frames(3, "R11");

    // enable cleared mid-frame
    setup(0, 16, 0, 0, 0, 2'b00, 2'b00, 16'd6, 3'd0, 2'b01, 1, 0);
    begin
      bit got = 0;
      while (!got) begin
        @(negedge clk); tx_valid = 1; tx_data = 16'h1234; #1;
        if (tx_ready) got = 1;
      end
      @(negedge clk); tx_valid = 0;
    end
    repeat (20) @(negedge clk);
    en = 0;
    @(negedge clk); #1;
    chk(ss_n == 2'b11, "R7", "selects released after disable", ss_n, 3);
    chk(rx_valid == 1'b0, "R7", "no word after disable", rx_valid, 0);
    en = 1;
    selx = 0;
    for (int i = 0; i < 150; i++) begin @(negedge clk); #1; if (rx_valid) selx = 1; end
    chk(!selx, "R7", "aborted frame yields no word", selx, 0);
    run_xfer(1, 1000);
    chk(rxcnt == 1 && rxw[0] == sword(0), "R7", "recovery after disable", rxw[0], sword(0));

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule